// File: doc/BRIEF.md
# Machine Timer and Software Interrupt Unit

This block serves one hart with a 64-bit free-running time counter, a 64-bit compare threshold and a software-interrupt flag. The counter advances on a one-cycle tick enable. The unit drives two level interrupt outputs. The timer interrupt is raised while the threshold is at or below the counter value. The software interrupt follows the flag that software writes.

Software reaches the three registers over a simple single-cycle register bus. A request carries an offset, a size code, a read/write flag and write data. The response comes one cycle later and carries read data and an error flag. Each register accepts only its exact access sizes. Every other combination of offset and size is refused with an error and changes nothing.

Top module: `mtimer_swint`

## Requirements
- R1: After reset the counter is 0, the software flag is 0, the threshold is all ones, and both interrupt outputs and `rsp_valid` are low.
- R2: The counter increases by exactly one on each clock edge where `tick` is high, and holds its value when `tick` is low.
- R3: The software-flag register sits at offset 0x0000 and accepts size codes 2 (4 bytes) and 3 (8 bytes). A write loads the flag from `req_wdata[0]`, and `soft_irq` follows the flag from the next cycle. A read returns the flag in bit 0, with all other bits zero.
- R4: The threshold register sits at offset 0x4000 and accepts only size code 3 (8 bytes). A write replaces all 64 bits, and a read returns them.
- R5: The counter sits at offset 0xBFF8 and can be read with size code 3. The read returns the count held on the clock edge where the request is accepted, which is the value before any tick on that same edge.
- R6: A write to offset 0xBFF8 is refused with `rsp_err` high, and the counter keeps counting as if no write had been made.
- R7: In every cycle after reset, `timer_irq` equals the unsigned comparison threshold <= counter, using the register values loaded on the preceding edge. This includes an edge where a threshold write and a tick happen together.
- R8: Any other offset, or any size code not listed in R3–R5, returns `rsp_err` high with `rsp_rdata` zero, and changes no register.
- R9: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. `rsp_rdata` is zero for every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable that advances the counter |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset into the unit |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access fault for the answered request |
| rsp_rdata | output | 64 | Read data, zero on fault or write |
| timer_irq | output | 1 | Machine timer interrupt pending |
| soft_irq | output | 1 | Machine software interrupt pending |

## Verification
A corrupted counter or threshold shows at the ports in two ways. The next read of that register returns a wrong value. `timer_irq` also switches in the wrong cycle around the crossing point, and the bench model catches that mismatch in the cycle right after the faulty edge. A wrong decode shows up in the same cycle as an unexpected fault flag, or as a register that later reads back changed after a refused access. The stimulus covers unsigned thresholds with the top bit set, so a signed comparison would raise `timer_irq` at once and be caught.

// File: rtl/mtsw_pkg.sv
package mtsw_pkg;
  typedef enum logic [1:0] {SZ_1B = 2'd0, SZ_2B = 2'd1, SZ_4B = 2'd2, SZ_8B = 2'd3} acc_size_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_SOFT, SRC_CMP, SRC_TIME} rd_src_e;
  localparam logic [15:0] OFF_SOFT = 16'h0000;
  localparam logic [15:0] OFF_CMP  = 16'h4000;
  localparam logic [15:0] OFF_TIME = 16'hBFF8;
endpackage

// File: rtl/mtsw_decode.sv
module mtsw_decode
  import mtsw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          valid,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic          wr_soft,
  output logic          wr_cmp,
  output rd_src_e       rd_src,
  output logic          fault
);
  localparam logic [AW-1:0] A_SOFT = AW'(OFF_SOFT);
  localparam logic [AW-1:0] A_CMP  = AW'(OFF_CMP);
  localparam logic [AW-1:0] A_TIME = AW'(OFF_TIME);

  acc_size_e sz;
  logic hit_soft, hit_cmp, hit_time_rd;

  always_comb begin
    sz          = acc_size_e'(size);
    hit_soft    = (addr == A_SOFT) && (sz == SZ_4B || sz == SZ_8B);
    hit_cmp     = (addr == A_CMP) && (sz == SZ_8B);
    hit_time_rd = (addr == A_TIME) && (sz == SZ_8B) && !write;
    wr_soft     = valid && write && hit_soft;
    wr_cmp      = valid && write && hit_cmp;
    fault       = valid && !(hit_soft || hit_cmp || hit_time_rd);
    rd_src      = SRC_NONE;
    if (valid && !write) begin
      if (hit_soft)         rd_src = SRC_SOFT;
      else if (hit_cmp)     rd_src = SRC_CMP;
      else if (hit_time_rd) rd_src = SRC_TIME;
    end
  end
endmodule

// File: rtl/mtsw_counter.sv
module mtsw_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] count_q,
  output logic [W-1:0] count_nxt
);
  always_comb count_nxt = tick ? count_q + W'(1) : count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_nxt;
  end

  assert_tick_advances_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> (count_q == $past(count_q) + W'(1)));
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count_q));
endmodule

// File: rtl/mtsw_compare.sv
module mtsw_compare #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] count_nxt,
  input  logic [W-1:0] count_q,
  output logic [W-1:0] cmp_q,
  output logic         pend_q
);
  logic [W-1:0] cmp_nxt;
  always_comb cmp_nxt = wr ? wdata : cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_nxt;
      pend_q <= (cmp_nxt <= count_nxt);
    end
  end

  assert_pend_matches_regs_R7: assert property (@(posedge clk) disable iff (rst)
    pend_q == (cmp_q <= count_q));
  assert_cmp_holds_R4: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(cmp_q));
endmodule

// File: rtl/mtimer_swint.sv
module mtimer_swint
  import mtsw_pkg::*;
#(
  parameter int AW = 16,
  parameter int W  = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [W-1:0]  req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [W-1:0]  rsp_rdata,
  output logic          timer_irq,
  output logic          soft_irq
);
  logic         wr_soft, wr_cmp, fault;
  rd_src_e      rd_src;
  logic [W-1:0] count_q, count_nxt, cmp_q, rd_mux;
  logic         soft_q;

  mtsw_decode #(.AW(AW)) u_dec (
    .valid(req_valid), .write(req_write), .addr(req_addr), .size(req_size),
    .wr_soft(wr_soft), .wr_cmp(wr_cmp), .rd_src(rd_src), .fault(fault)
  );

  mtsw_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .count_q(count_q), .count_nxt(count_nxt)
  );

  mtsw_compare #(.W(W)) u_cmp (
    .clk(clk), .rst(rst), .wr(wr_cmp), .wdata(req_wdata),
    .count_nxt(count_nxt), .count_q(count_q), .cmp_q(cmp_q), .pend_q(timer_irq)
  );

  always_comb begin
    unique case (rd_src)
      SRC_SOFT: rd_mux = {{(W-1){1'b0}}, soft_q};
      SRC_CMP:  rd_mux = cmp_q;
      SRC_TIME: rd_mux = count_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr_soft) soft_q <= req_wdata[0];
      rsp_valid <= req_valid;
      rsp_err   <= fault;
      rsp_rdata <= rd_mux;
    end
  end

  always_comb soft_irq = soft_q;

  assert_rsp_after_req_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_fault_zero_data_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
  assert_time_write_faults_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == AW'(OFF_TIME)) |=> rsp_err);
  assert_soft_write_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == AW'(OFF_SOFT) && req_size[1]) |=> (soft_irq == $past(req_wdata[0])));
endmodule

// File: tb/mtimer_swint_test.sv
module mtimer_swint_test;
  logic clk = 0, rst = 1, tick = 0, req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [1:0]  req_size = 0;
  logic [63:0] req_wdata = 0;
  logic rsp_valid, rsp_err, timer_irq, soft_irq;
  logic [63:0] rsp_rdata;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mtimer_swint uut (.*);

  // behavioural reference state
  logic [63:0] m_time, m_cmp, m_rd;
  logic m_soft, m_rv, m_err, m_irq;
  string m_tag;
  logic ok_acc;

  always @(posedge clk) begin
    if (rst) begin
      m_time = 0; m_cmp = '1; m_soft = 0; m_rv = 0; m_err = 0; m_rd = 0; m_irq = 0; m_tag = "R1";
    end else begin
      m_rv = req_valid; m_err = 0; m_rd = 0; m_tag = "R9";
      if (req_valid) begin
        ok_acc = 0;
        if (req_addr == 16'h0000 && req_size >= 2) begin
          ok_acc = 1; m_tag = "R3";
          if (req_write) m_soft = req_wdata[0]; else m_rd = {63'b0, m_soft};
        end else if (req_addr == 16'h4000 && req_size == 3) begin
          ok_acc = 1; m_tag = "R4";
          if (!req_write) m_rd = m_cmp;
        end else if (req_addr == 16'hBFF8 && req_size == 3 && !req_write) begin
          ok_acc = 1; m_tag = "R5"; m_rd = m_time;
        end
        if (!ok_acc) begin
          m_err = 1;
          m_tag = (req_addr == 16'hBFF8 && req_write) ? "R6" : "R8";
        end
        if (ok_acc && req_write && req_addr == 16'h4000) m_cmp = req_wdata;
      end
      if (tick) m_time = m_time + 1;
      m_irq = (m_cmp <= m_time);
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      chk("R1", {62'b0, timer_irq, soft_irq}, 64'd0);
    end else begin
      chk("R7", {63'b0, timer_irq}, {63'b0, m_irq});
      chk("R3", {63'b0, soft_irq}, {63'b0, m_soft});
      chk("R9", {63'b0, rsp_valid}, {63'b0, m_rv});
      if (m_rv) begin
        chk(m_tag, {63'b0, rsp_err}, {63'b0, m_err});
        chk(m_tag, rsp_rdata, m_rd);
      end
    end
  end

  task automatic op(input logic v, input logic w, input logic [15:0] a,
                    input logic [1:0] s, input logic [63:0] d, input logic t);
    req_valid = v; req_write = w; req_addr = a; req_size = s; req_wdata = d; tick = t;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    op(1, 0, 16'h4000, 3, 0, 0);            // R1: threshold reads all ones
    op(1, 0, 16'hBFF8, 3, 0, 0);            // R1: counter reads zero
    for (int i = 0; i < 10; i++) op(0, 0, 0, 0, 0, i % 3 != 0);  // R2 ticking pattern
    op(1, 0, 16'hBFF8, 3, 0, 1);            // R5 read with simultaneous tick
    op(1, 0, 16'hBFF8, 3, 0, 0);
    op(1, 1, 16'h0000, 2, 64'h1, 0);        // R3 4-byte set
    op(1, 0, 16'h0000, 3, 0, 0);
    op(1, 1, 16'h0000, 3, 64'hFFFE, 0);     // R3 8-byte clear via bit 0
    op(1, 0, 16'h0000, 2, 0, 0);
    op(1, 1, 16'h0000, 1, 64'h1, 0);        // R8 bad size
    op(1, 0, 16'h0000, 2, 0, 0);
    op(1, 1, 16'h4000, 3, 64'd20, 1);       // R4/R7 threshold above count
    op(1, 0, 16'h4000, 3, 0, 0);
    for (int i = 0; i < 16; i++) op(0, 0, 0, 0, 0, 1);  // R7 crossing
    op(1, 1, 16'h4000, 3, 64'h8000_0000_0000_0000, 0);  // R7 unsigned
    op(0, 0, 0, 0, 0, 1);
    op(1, 1, 16'h4000, 3, 64'd0, 1);        // R7 write + tick together
    op(1, 1, 16'hBFF8, 3, 64'd5, 1);        // R6 refused write
    op(1, 0, 16'hBFF8, 3, 0, 0);
    op(1, 1, 16'h4000, 2, 64'd1, 0);        // R8 partial threshold write
    op(1, 0, 16'h4000, 3, 0, 0);
    op(1, 0, 16'h4004, 2, 0, 0);            // R8 bad offset
    op(1, 0, 16'hBFF8, 2, 0, 0);            // R8 bad size
    op(1, 1, 16'h1234, 3, 64'hF, 0);
    op(1, 1, 16'h4000, 3, 64'd60, 1);
    for (int i = 0; i < 40; i++) op(i % 4 == 1, 0, 16'hBFF8, 3, 0, 1);
    op(1, 1, 16'h4000, 3, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    op(0, 0, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule